// File: doc/BRIEF.md
# Per-Core Local-to-Global Address Aliaser

This block sits on the outgoing address path of a three-core system. Every core can reach its own second-level memory through one shared local window, so a single software image runs unchanged on every core. The block rewrites addresses in that window into the requesting core's system-wide global window. Global addresses and addresses outside the window pass through untouched. Requests from masters that are not cores never use the local alias, so those requests are never rewritten.

The local window is 2 MB wide, starting at 0x0080_0000. It is divided into four 512 KB slices, and only the two lowest slices hold memory. When a core touches either upper slice, the request is flagged as an error and is not rewritten. A core index outside the range of existing cores is also flagged as an error. The translation itself is combinational.

A request travels as one beat on a valid/ready stream and passes through a single output register. The input accepts a beat whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and the input stalls.

Top module: `local_alias_xlate`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A core request with index 0..2 and an address in 0x0080_0000..0x008F_FFFF is rewritten to address − 0x0080_0000 + 0x1080_0000 + index × 0x0100_0000. It carries `out_xlated`=1 and `out_err`=0.
- R3: A core request with a legal index and an address in 0x0090_0000..0x009F_FFFF leaves the address unchanged. It carries `out_err`=1 and `out_xlated`=0.
- R4: A core request with index 3 leaves the address unchanged at any address. It carries `out_err`=1 and `out_xlated`=0.
- R5: A core request with a legal index and an address below 0x0080_0000 or above 0x009F_FFFF passes unchanged, with both flags 0.
- R6: A request with `in_from_core`=0 passes unchanged at any address with both flags 0, whatever the value of `in_core`.
- R7: While `out_valid`=1 and `out_ready`=0, the output beat stays stable and `in_ready` is 0.
- R8: A beat accepted in one cycle appears on the output after the next clock edge, and beats leave in the order they were accepted.
- R9: `out_xlated` and `out_err` are never both 1 on a valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_from_core | input | 1 | 1 when the requester is a core, 0 for any other master |
| in_core | input | 2 | Index of the requesting core |
| in_addr | input | 32 | Access address |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_addr | output | 32 | Global or passed-through address |
| out_xlated | output | 1 | Address was rewritten |
| out_err | output | 1 | Inaccessible slice or illegal core index |

## Verification
The bench sweeps every core index, both requester kinds and a set of addresses: one word either side of each window edge, and the first, an inner and the last word of every slice. Each beat is checked against arithmetic computed in the bench. An off-by-one window compare would mis-handle 0x007F_FFFC or 0x00A0_0000. A wrong slice decode would translate into the holes or flag populated memory. A wrong base per core would land core 1 or core 2 in the wrong global window. Ignoring the requester kind would rewrite requests from non-core masters. A separate stall sequence checks that a broken ready path would overwrite a held beat or drop the stalled one.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              xlated;
    logic              err;
  } alias_beat_t;
endpackage

// File: rtl/alias_window_decode.sv
module alias_window_decode #(
  parameter int                  ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]   LOCAL_BASE = 32'h0080_0000,
  parameter int                  SLICE_W    = 19,
  parameter int                  NUM_SLICES = 4,
  parameter int                  POPULATED  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              populated,
  output logic [ADDR_W-1:0] offset
);
  localparam int IDX_W = $clog2(NUM_SLICES);
  localparam int WIN_W = SLICE_W + IDX_W;
  localparam logic [ADDR_W-WIN_W-1:0] WIN_TAG = LOCAL_BASE[ADDR_W-1:WIN_W];

  logic [IDX_W-1:0] slice_idx;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_W] == WIN_TAG);
    slice_idx = addr[WIN_W-1:SLICE_W];
    populated = (32'(slice_idx) < POPULATED);
    offset    = {{(ADDR_W-WIN_W){1'b0}}, addr[WIN_W-1:0]};
  end
endmodule

// File: rtl/alias_base_select.sv
module alias_base_select #(
  parameter int                ADDR_W      = 32,
  parameter int                CORE_W      = 2,
  parameter int                NUM_CORES   = 3,
  parameter logic [ADDR_W-1:0] GLOBAL_BASE = 32'h1080_0000,
  parameter logic [ADDR_W-1:0] CORE_STRIDE = 32'h0100_0000
) (
  input  logic [CORE_W-1:0] core_idx,
  output logic              core_ok,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] bases [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_base
    assign bases[g] = GLOBAL_BASE + ADDR_W'(g) * CORE_STRIDE;
  end

  always_comb begin
    core_ok = 1'b0;
    base    = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_idx == CORE_W'(i)) begin
        core_ok = 1'b1;
        base    = bases[i];
      end
    end
  end
endmodule

// File: rtl/alias_out_stage.sv
module alias_out_stage
  import alias_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  alias_beat_t in_beat,
  output logic        out_valid,
  input  logic        out_ready,
  output alias_beat_t out_beat
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_beat <= in_beat;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_beat == $past(in_beat)));
endmodule

// File: rtl/local_alias_xlate.sv
module local_alias_xlate
  import alias_pkg::*;
#(
  parameter int                CORE_W      = 2,
  parameter int                NUM_CORES   = 3,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 32'h0080_0000,
  parameter int                SLICE_W     = 19,
  parameter int                NUM_SLICES  = 4,
  parameter int                POPULATED   = 2,
  parameter logic [ADDR_W-1:0] GLOBAL_BASE = 32'h1080_0000,
  parameter logic [ADDR_W-1:0] CORE_STRIDE = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_from_core,
  input  logic [CORE_W-1:0] in_core,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_xlated,
  output logic              out_err
);
  localparam logic [ADDR_W:0] GLOBAL_END =
    {1'b0, GLOBAL_BASE} + (ADDR_W+1)'(NUM_CORES) * {1'b0, CORE_STRIDE};

  logic              in_window, populated, core_ok;
  logic [ADDR_W-1:0] offset, base;
  alias_beat_t       next_beat, held_beat;
  logic              do_xlate;

  alias_window_decode #(
    .ADDR_W(ADDR_W), .LOCAL_BASE(LOCAL_BASE), .SLICE_W(SLICE_W),
    .NUM_SLICES(NUM_SLICES), .POPULATED(POPULATED)
  ) i_decode (
    .addr(in_addr), .in_window(in_window), .populated(populated), .offset(offset)
  );

  alias_base_select #(
    .ADDR_W(ADDR_W), .CORE_W(CORE_W), .NUM_CORES(NUM_CORES),
    .GLOBAL_BASE(GLOBAL_BASE), .CORE_STRIDE(CORE_STRIDE)
  ) i_base (
    .core_idx(in_core), .core_ok(core_ok), .base(base)
  );

  always_comb begin
    do_xlate         = in_from_core && core_ok && in_window && populated;
    next_beat.xlated = do_xlate;
    next_beat.err    = in_from_core && (!core_ok || (in_window && !populated));
    next_beat.addr   = do_xlate ? (base + offset) : in_addr;
  end

  alias_out_stage i_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_beat(next_beat),
    .out_valid(out_valid), .out_ready(out_ready), .out_beat(held_beat)
  );

  assign out_addr   = held_beat.addr;
  assign out_xlated = held_beat.xlated;
  assign out_err    = held_beat.err;

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_xlated && out_err));

  p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !do_xlate) |=> (out_addr == $past(in_addr)));

  p_xlate_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_xlated) |->
      ({1'b0, out_addr} >= {1'b0, GLOBAL_BASE} && {1'b0, out_addr} < GLOBAL_END));
endmodule

// File: tb/test_local_alias_xlate.sv
module test_local_alias_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_from_core = 1'b0;
  logic [1:0]  in_core = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_xlated;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  local_alias_xlate i_local_alias_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_from_core(in_from_core), .in_core(in_core), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_xlated(out_xlated), .out_err(out_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input bit fc, input int core, input logic [31:0] a);
    if (!fc) return "R6";
    if (core >= 3) return "R4";
    if (a >= 32'h0080_0000 && a <= 32'h008F_FFFF) return "R2";
    if (a >= 32'h0090_0000 && a <= 32'h009F_FFFF) return "R3";
    return "R5";
  endfunction

  task automatic send_check(input bit fc, input int core, input logic [31:0] a);
    logic [31:0] e_addr;
    logic        e_x, e_e;
    string       t;
    t = tag_of(fc, core, a);
    e_addr = a; e_x = 1'b0; e_e = 1'b0;
    if (t == "R2") begin
      e_addr = a - 32'h0080_0000 + 32'h1080_0000 + 32'(core) * 32'h0100_0000;
      e_x = 1'b1;
    end else if (t == "R3" || t == "R4") begin
      e_e = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b1; in_from_core = fc; in_core = 2'(core); in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({t, " R8 valid"}, {63'd0, out_valid}, 64'd1);
    check({t, " addr"}, {32'd0, out_addr}, {32'd0, e_addr});
    check({t, " R9 flags"}, {62'd0, out_xlated, out_err}, {62'd0, e_x, e_e});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {63'd0, out_valid}, 64'd0);

    for (int fc = 0; fc < 2; fc++) begin
      for (int core = 0; core < 4; core++) begin
        for (int s = -1; s <= 4; s++) begin
          send_check(fc[0], core, 32'h0080_0000 + 32'(s * 32'h0008_0000));
          send_check(fc[0], core, 32'h0080_1234 + 32'(s * 32'h0008_0000));
          send_check(fc[0], core, 32'h0087_FFFC + 32'(s * 32'h0008_0000));
        end
        send_check(fc[0], core, 32'h0000_0000);
        send_check(fc[0], core, 32'hFFFF_FFFF);
        send_check(fc[0], core, 32'h1080_0000);
        send_check(fc[0], core, 32'h009F_FFFF);
        send_check(fc[0], core, 32'h007F_FFFF);
      end
    end

    // R7 stall, then R8 ordering
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_from_core = 1'b1; in_core = 2'd1; in_addr = 32'h0080_0010;
    @(negedge clk);
    in_addr = 32'h0080_0020; in_core = 2'd2;
    for (int k = 0; k < 4; k++) begin
      check("R7 held valid", {63'd0, out_valid}, 64'd1);
      check("R7 held addr", {32'd0, out_addr}, {32'd0, 32'h1180_0010});
      check("R7 in_ready low", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second beat addr", {32'd0, out_addr}, {32'd0, 32'h1280_0020});
    check("R8 second beat valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R8 drained", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule